// File: doc/BRIEF.md
# Flash Program and Erase Completion Poller

This block is a host-side engine that drives one write operation on a parallel byte-wide flash device. The device is either programmed one byte at a time or erased as a whole chip. A requester hands over one job through a valid/ready request port. The job carries the operation, the polling style, the target address and the byte. The block then issues the keyed command writes on a simple bus master port. Next it reads the device repeatedly until the device reports that its internal operation has finished. A last read then confirms the stored contents.

Completion is taken from the device's own status, not from a fixed delay. In complement style the block reads the target address and waits for bit 7 to match the bit 7 that was written. In toggle style it waits until two successive reads return the same bit 6. An erase always uses toggle style. A poll limit bounds the wait. The result is a one-cycle `done` pulse, qualified by `err` (the verify read did not match) or `tmo` (the poll limit was reached).

The request port applies back-pressure. `req_ready` is high only while the engine is idle. A job is taken on the cycle where `req_valid` and `req_ready` are both high, and `req_valid` is ignored at all other times. On the bus port the engine holds `bus_valid` and all its fields steady until the device side raises `bus_ready`. The transfer happens on the cycle where both are high, and `bus_rdata` is sampled on that same cycle.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `bus_valid` is 0 and `done`, `err`, `tmo` are 0.
- R2: A job is accepted only on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from that cycle until the engine is idle again, and a `req_valid` raised while busy has no effect on the running job.
- R3: A program job (`req_erase`=0) writes, in order, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then the target address with the request byte.
- R4: An erase job (`req_erase`=1) writes, in order, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x10.
- R5: Once `bus_valid` is high, it stays high with `bus_we`, `bus_addr` and `bus_wdata` unchanged until a cycle with `bus_ready` high. Exactly one transfer takes place per such cycle, and `bus_valid` is 0 while `req_ready` is 1.
- R6: In complement style (`req_toggle`=0 on a program job), each poll reads the target address. The operation is complete at the first read whose bit 7 equals bit 7 of the written byte.
- R7: In toggle style (`req_toggle`=1, or any erase job), the operation is complete at the first poll read whose bit 6 equals bit 6 of the poll read just before it in the same job.
- R8: The first read of a job is the next bus transfer after its last command write. No other transfer comes between them.
- R9: If `MAX_POLLS` poll reads pass without completion, the engine issues no further read. It pulses `done` with `tmo`=1 and returns to idle.
- R10: After completion the engine makes exactly one verify read of the target address. It compares the value with the request byte (program) or with all ones (erase), and `err`=1 marks a mismatch.
- R11: `done` is high for exactly one cycle per job. `err` and `tmo` are high only together with `done`, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Job offered |
| req_ready | output | 1 | Engine idle, job can be taken |
| req_erase | input | 1 | 1 = chip erase, 0 = byte program |
| req_toggle | input | 1 | 1 = toggle-style polling, 0 = complement style (program only) |
| req_addr | input | AW | Target byte address |
| req_data | input | DW | Byte to program |
| bus_valid | output | 1 | Bus transfer requested |
| bus_ready | input | 1 | Device side accepts the transfer |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Transfer address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid in the transfer cycle |
| done | output | 1 | One-cycle job completion pulse |
| err | output | 1 | Verify mismatch, with `done` |
| tmo | output | 1 | Poll limit reached, with `done` |

## Verification
The bench sweeps the number of busy reads of a modelled device across the poll limit, for every combination of operation, polling style and a deliberately corrupted final byte. It uses a randomly stalled `bus_ready`. The key edges are completion on the very first poll and completion on exactly the last allowed poll. An off-by-one in the poll counter either times out a job that should pass or issues one read too many. In toggle style the first read has no predecessor. A design that treats it as a match, or that applies complement style to an erase, finishes early and reads the wrong byte count. A corrupted final byte must raise `err`, and a timed-out job must skip the verify read. A design that verifies anyway shows one extra read.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMD   = 2'd1,
    ST_POLL  = 2'd2,
    ST_CHECK = 2'd3
  } fpc_state_t;

  localparam logic [14:0] KEY_ADDR_A = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_DAT_A  = 8'hAA;
  localparam logic [7:0]  KEY_DAT_B  = 8'h55;
  localparam logic [7:0]  OP_PROG    = 8'hA0;
  localparam logic [7:0]  OP_ERASE_1 = 8'h80;
  localparam logic [7:0]  OP_ERASE_2 = 8'h10;
  localparam int          STEP_W     = 3;
endpackage

// File: rtl/fpc_cmd_table.sv
module fpc_cmd_table
  import fpc_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic              is_erase,
  input  logic [STEP_W-1:0] step,
  input  logic [AW-1:0]     tgt_addr,
  input  logic [DW-1:0]     tgt_data,
  output logic [AW-1:0]     cmd_addr,
  output logic [DW-1:0]     cmd_data,
  output logic              cmd_last
);
  localparam logic [AW-1:0] ADDR_A = AW'(KEY_ADDR_A);
  localparam logic [AW-1:0] ADDR_B = AW'(KEY_ADDR_B);

  always_comb begin
    cmd_addr = ADDR_A;
    cmd_data = DW'(KEY_DAT_A);
    cmd_last = 1'b0;
    unique case (step)
      3'd0: begin cmd_addr = ADDR_A; cmd_data = DW'(KEY_DAT_A); end
      3'd1: begin cmd_addr = ADDR_B; cmd_data = DW'(KEY_DAT_B); end
      3'd2: begin
        cmd_addr = ADDR_A;
        cmd_data = is_erase ? DW'(OP_ERASE_1) : DW'(OP_PROG);
      end
      3'd3: begin
        if (is_erase) begin
          cmd_addr = ADDR_A; cmd_data = DW'(KEY_DAT_A);
        end else begin
          cmd_addr = tgt_addr; cmd_data = tgt_data; cmd_last = 1'b1;
        end
      end
      3'd4: begin cmd_addr = ADDR_B; cmd_data = DW'(KEY_DAT_B); end
      3'd5: begin cmd_addr = ADDR_A; cmd_data = DW'(OP_ERASE_2); cmd_last = 1'b1; end
      default: begin cmd_addr = ADDR_A; cmd_data = DW'(KEY_DAT_A); cmd_last = 1'b1; end
    endcase
  end
endmodule

// File: rtl/fpc_poll_judge.sv
module fpc_poll_judge #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sample,
  input  logic          use_toggle,
  input  logic          exp_bit7,
  input  logic [DW-1:0] rdata,
  output logic          complete
);
  logic have_prev;
  logic prev_b6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_b6   <= 1'b0;
    end else if (clear) begin
      have_prev <= 1'b0;
    end else if (sample) begin
      have_prev <= 1'b1;
      prev_b6   <= rdata[6];
    end
  end

  always_comb begin
    if (use_toggle) complete = have_prev && (rdata[6] == prev_b6);
    else            complete = (rdata[7] == exp_bit7);
  end
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import fpc_pkg::*;
#(
  parameter int AW        = 19,
  parameter int DW        = 8,
  parameter int MAX_POLLS = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_erase,
  input  logic          req_toggle,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic          err,
  output logic          tmo
);
  localparam int PCW = $clog2(MAX_POLLS + 1);
  localparam logic [PCW-1:0] POLL_LAST = PCW'(MAX_POLLS - 1);

  fpc_state_t        state;
  logic              op_erase, op_toggle;
  logic [AW-1:0]     op_addr;
  logic [DW-1:0]     op_data;
  logic [STEP_W-1:0] step;
  logic [PCW-1:0]    polls;
  logic              done_q, err_q, tmo_q;

  logic [AW-1:0] tbl_addr;
  logic [DW-1:0] tbl_data;
  logic          tbl_last;
  logic          xfer, fin, accept;
  logic [DW-1:0] expect_byte;

  assign accept    = req_valid && req_ready;
  assign req_ready = (state == ST_IDLE);
  assign bus_valid = (state != ST_IDLE);
  assign bus_we    = (state == ST_CMD);
  assign bus_addr  = (state == ST_CMD) ? tbl_addr : op_addr;
  assign bus_wdata = tbl_data;
  assign xfer      = bus_valid && bus_ready;
  assign expect_byte = op_erase ? {DW{1'b1}} : op_data;
  assign done = done_q;
  assign err  = err_q;
  assign tmo  = tmo_q;

  fpc_cmd_table #(.AW(AW), .DW(DW)) u_table (
    .is_erase (op_erase),
    .step     (step),
    .tgt_addr (op_addr),
    .tgt_data (op_data),
    .cmd_addr (tbl_addr),
    .cmd_data (tbl_data),
    .cmd_last (tbl_last)
  );

  fpc_poll_judge #(.DW(DW)) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (accept),
    .sample     (xfer && (state == ST_POLL)),
    .use_toggle (op_toggle),
    .exp_bit7   (op_data[7]),
    .rdata      (bus_rdata),
    .complete   (fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_erase  <= 1'b0;
      op_toggle <= 1'b0;
      op_addr   <= '0;
      op_data   <= '0;
      step      <= '0;
      polls     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          op_erase  <= req_erase;
          op_toggle <= req_erase | req_toggle;
          op_addr   <= req_addr;
          op_data   <= req_data;
          step      <= '0;
          state     <= ST_CMD;
        end
        ST_CMD: if (xfer) begin
          if (tbl_last) begin
            polls <= '0;
            state <= ST_POLL;
          end else begin
            step <= step + 1'b1;
          end
        end
        ST_POLL: if (xfer) begin
          if (fin) begin
            state <= ST_CHECK;
          end else if (polls == POLL_LAST) begin
            done_q <= 1'b1;
            tmo_q  <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            polls <= polls + 1'b1;
          end
        end
        ST_CHECK: if (xfer) begin
          done_q <= 1'b1;
          err_q  <= (bus_rdata != expect_byte);
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          done,
  input logic          err,
  input logic          tmo
);
  // R5
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_we) &&
                                   $stable(bus_addr) && $stable(bus_wdata)));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && bus_valid));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  flag_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err || tmo) |-> done);

  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && tmo));

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

bind flash_poll_ctrl fpc_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .done      (done),
  .err       (err),
  .tmo       (tmo)
);

// File: tb/flash_poll_ctrl_test.sv
module flash_poll_ctrl_test;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int MAXP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_erase = 1'b0, req_toggle = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, bus_valid, bus_we, done, err, tmo;
  logic bus_ready = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] lfsr = 8'h5B;

  // device model state
  int m_busy = 0, m_wr = 0, m_rd = 0;
  logic [DW-1:0] m_final = '0;
  logic m_order_bad = 1'b0;
  int m_exp_wr = 0;
  logic [AW-1:0] w_addr [8];
  logic [DW-1:0] w_data [8];
  logic [AW-1:0] r_addr_last = '0;

  always #5 clk = ~clk;

  flash_poll_ctrl #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_toggle(req_toggle), .req_addr(req_addr),
    .req_data(req_data), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done(done), .err(err), .tmo(tmo)
  );

  // busy reads: bit7 inverted, bit6 alternating so the last busy read differs from final
  always_comb begin
    if (m_rd + 1 <= m_busy)
      bus_rdata = {~m_final[7], m_final[6] ^ logic'((m_busy - m_rd) & 1), m_final[5:0]};
    else
      bus_rdata = m_final;
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bus_ready <= lfsr[0] | lfsr[3];
  end

  always @(posedge clk) begin
    if (bus_valid && bus_ready) begin
      if (bus_we) begin
        if (m_wr < 8) begin w_addr[m_wr] <= bus_addr; w_data[m_wr] <= bus_wdata; end
        m_wr <= m_wr + 1;
      end else begin
        if (m_wr != m_exp_wr) m_order_bad <= 1'b1;
        r_addr_last <= bus_addr;
        m_rd <= m_rd + 1;
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_job(input bit erase, input bit tog, input int busy, input bit corrupt,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [AW-1:0] ea [6];
    logic [DW-1:0] ed [6];
    int nw, need, exp_rd, waited;
    bit use_tog, exp_tmo, exp_err, got_err, got_tmo;
    use_tog = erase | tog;
    nw = erase ? 6 : 4;
    ea[0] = 19'h5555; ed[0] = 8'hAA;
    ea[1] = 19'h2AAA; ed[1] = 8'h55;
    ea[2] = 19'h5555; ed[2] = erase ? 8'h80 : 8'hA0;
    ea[3] = erase ? 19'h5555 : a; ed[3] = erase ? 8'hAA : d;
    ea[4] = 19'h2AAA; ed[4] = 8'h55;
    ea[5] = 19'h5555; ed[5] = 8'h10;
    if (!use_tog) need = busy + 1;
    else need = (busy == 0) ? 2 : busy + 2;
    exp_tmo = (need > MAXP);
    exp_err = !exp_tmo && corrupt;
    exp_rd = exp_tmo ? MAXP : need + 1;

    @(negedge clk);
    m_busy = busy; m_wr = 0; m_rd = 0; m_order_bad = 1'b0; m_exp_wr = nw;
    m_final = (erase ? 8'hFF : d) ^ (corrupt ? 8'h01 : 8'h00);
    req_valid = 1'b1; req_erase = erase; req_toggle = tog; req_addr = a; req_data = d;
    @(negedge clk);
    // R2: ready drops after acceptance; a second offer while busy is ignored
    check(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
    req_addr = a ^ 19'h00F0; req_data = ~d; req_erase = ~erase;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!done && waited < 400) begin @(negedge clk); waited++; end
    got_err = err; got_tmo = tmo;
    check(done == 1'b1, "R11 done seen", done, 1);
    check(m_wr == nw, erase ? "R4 write count" : "R3 write count", m_wr, nw);
    for (int i = 0; i < nw && i < m_wr; i++) begin
      check(w_addr[i] == ea[i] && w_data[i] == ed[i],
            erase ? "R4 R5 write addr/data" : "R3 R5 write addr/data",
            int'({w_addr[i], w_data[i]}), int'({ea[i], ed[i]}));
    end
    check(!m_order_bad, "R8 reads follow last write", m_order_bad, 0);
    check(m_rd == exp_rd, use_tog ? "R7 R9 R10 read count" : "R6 R9 R10 read count",
          m_rd, exp_rd);
    check(r_addr_last == a, "R6 read address", int'(r_addr_last), int'(a));
    check(got_tmo == exp_tmo, "R9 timeout flag", got_tmo, exp_tmo);
    check(got_err == exp_err, "R10 error flag", got_err, exp_err);
    @(negedge clk);
    check(done == 1'b0 && err == 1'b0 && tmo == 1'b0, "R11 one-cycle pulse",
          int'({done, err, tmo}), 0);
    check(req_ready == 1'b1 && bus_valid == 1'b0, "R2 idle again",
          int'({req_ready, bus_valid}), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && bus_valid == 1'b0 && done == 1'b0 && err == 1'b0 && tmo == 1'b0,
          "R1 reset state", int'({req_ready, bus_valid, done, err, tmo}), 16);
    rst_n = 1'b1;
    @(negedge clk);
    for (int op = 0; op < 2; op++)
      for (int md = 0; md < 2; md++)
        for (int bz = 0; bz <= MAXP + 1; bz++)
          for (int cr = 0; cr < 2; cr++)
            run_job(op[0], md[0], bz, cr[0], AW'(19'h12345 + bz * 19'h01111),
                    DW'(8'h3C ^ (bz * 8'h25) ^ (md * 8'hC0)));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule